// File: doc/BRIEF.md
# Time-Triggered Cycle Status Flags

This block produces the sticky status flags of a time-triggered bus controller. It owns a small basic-cycle counter that steps on a one-clock "basic cycle start" pulse. The counter returns to zero after it reaches a programmed maximum, and software can reload it with a programmed initial value. The block also watches the running cycle-time count that an external timer supplies, and compares it with a programmed compare value.

Two events raise sticky flags. A new system matrix is flagged when the cycle counter wraps from its maximum to zero. It is also flagged when a time reference message completes while the counter is at zero and the maximum is not all ones. A compare match is flagged when the enabled compare value equals the cycle-time count. Software reads the flags through a 16-bit read-only status word, which has no write path. Each flag has a companion interrupt request bit, and that bit is the only way to clear the flag: software pulses its write-one-to-clear strobe. All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `tt_cycle_status`

## Requirements
- R1: After reset, the status word is 16'h0000, both interrupt request outputs are 0 and the cycle count is 0.
- R2: Status word bits 15 to 5 and bits 2 to 0 always read 0. Bit 4 is the new-matrix flag and bit 3 is the compare-match flag. The word has no write path.
- R3: The cycle count is 3 bits wide. A `cycle_start` pulse advances it by one, or to 0 when it equals `cfg_cycle_max`. A `cycle_reload` pulse loads `cfg_cycle_init` and takes priority over `cycle_start` in the same clock.
- R4: A wrap of the cycle count from `cfg_cycle_max` to 0 sets bit 4 and `irq_matrix` at the same clock edge. This also holds for a maximum of 7.
- R5: A `ref_done` pulse sets bit 4 and `irq_matrix` only when the current cycle count is 0 and `cfg_cycle_max` is not 3'b111. Otherwise it leaves them unchanged.
- R6: Bit 4 and `irq_matrix` clear only on a `clr_matrix_irq` pulse. If a set event occurs in the same clock, the set wins.
- R7: When `cmp_en` is 1 and `cycle_time` equals `cmp_value`, bit 3 and `irq_compare` are 1 after the next clock edge. While `cmp_en` is 0, equality sets nothing.
- R8: Bit 3 and `irq_compare` clear only on a `clr_compare_irq` pulse. A match in the same clock wins over the clear, so the flag stays set while the values remain equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_start | input | 1 | One-clock basic cycle start pulse |
| cycle_reload | input | 1 | One-clock pulse that loads the initial cycle value |
| ref_done | input | 1 | One-clock pulse when a time reference message completes successfully |
| cfg_cycle_max | input | 3 | Highest cycle count before the counter wraps |
| cfg_cycle_init | input | 3 | Value loaded by `cycle_reload` |
| cmp_en | input | 1 | Compare enable |
| cmp_value | input | 16 | Compare value |
| cycle_time | input | 16 | Running cycle-time count |
| clr_matrix_irq | input | 1 | Write-one-to-clear strobe for the new-matrix interrupt bit |
| clr_compare_irq | input | 1 | Write-one-to-clear strobe for the compare interrupt bit |
| status_word | output | 16 | Read-only status word |
| irq_matrix | output | 1 | New-matrix interrupt request bit |
| irq_compare | output | 1 | Compare-match interrupt request bit |
| cycle_count | output | 3 | Current basic-cycle count |

## Verification
The bench hits the set/clear collisions for both flags. A design that lets the clear win would drop a wrap that lands in the same clock as the clear, or drop a match that is still present. It sends reference completions at a non-zero count and with a maximum of all ones. A design that ignores the gate would raise the new-matrix flag there. It also drives equality while compare is disabled, and a reload together with a start pulse. Either mistake shows up directly on the status word or on the cycle count.

// File: rtl/tt_status_pkg.sv
package tt_status_pkg;
  localparam int CNT_W    = 3;
  localparam int TIME_W   = 16;
  localparam int STAT_W   = 16;
  localparam int NFLAG    = 2;
  // flag indices in the flag vector
  localparam int FLG_MATRIX  = 0;
  localparam int FLG_COMPARE = 1;
  // bit positions in the status word
  localparam int POS_MATRIX  = 4;
  localparam int POS_COMPARE = 3;
endpackage

// File: rtl/tt_cycle_counter.sv
module tt_cycle_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reload,
  input  logic [CNT_W-1:0] max_val,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt;

  assign wrap    = start && !reload && (count == max_val);
  assign at_zero = (count == '0);

  always_comb begin
    nxt = count;
    if (reload)       nxt = init_val;
    else if (wrap)    nxt = '0;
    else if (start)   nxt = count + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R3: a wrap lands on zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !reload && count == max_val) |=> (count == '0));
  // R3: reload wins over start
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (count == $past(init_val)));
  // R3: idle holds the count
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !reload) |=> $stable(count));
endmodule

// File: rtl/tt_compare_unit.sv
module tt_compare_unit #(
  parameter int TIME_W = 16
) (
  input  logic              en,
  input  logic [TIME_W-1:0] cmp_value,
  input  logic [TIME_W-1:0] cycle_time,
  output logic              match
);
  assign match = en && (cmp_value == cycle_time);

  // R7: disabled compare never matches
  always_comb begin
    p_disabled_r7: assert (en || !match);
  end
endmodule

// File: rtl/tt_sticky_flag.sv
module tt_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R6 and R8: set beats a simultaneous clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R6 and R8: clear alone empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && clr) |=> !q);
  // R6 and R8: no event, no change
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/tt_cycle_status.sv
module tt_cycle_status
  import tt_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              cycle_reload,
  input  logic              ref_done,
  input  logic [CNT_W-1:0]  cfg_cycle_max,
  input  logic [CNT_W-1:0]  cfg_cycle_init,
  input  logic              cmp_en,
  input  logic [TIME_W-1:0] cmp_value,
  input  logic [TIME_W-1:0] cycle_time,
  input  logic              clr_matrix_irq,
  input  logic              clr_compare_irq,
  output logic [STAT_W-1:0] status_word,
  output logic              irq_matrix,
  output logic              irq_compare,
  output logic [CNT_W-1:0]  cycle_count
);
  logic             wrap, at_zero, match, ref_ok;
  logic [NFLAG-1:0] set_v, clr_v, flag_q, irq_q;

  tt_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(cycle_start), .reload(cycle_reload),
    .max_val(cfg_cycle_max), .init_val(cfg_cycle_init),
    .count(cycle_count), .wrap(wrap), .at_zero(at_zero));

  tt_compare_unit #(.TIME_W(TIME_W)) u_cmp (
    .en(cmp_en), .cmp_value(cmp_value), .cycle_time(cycle_time),
    .match(match));

  // reference completion counts only at cycle zero with a bounded maximum
  assign ref_ok = ref_done && at_zero && (cfg_cycle_max != '1);

  assign set_v[FLG_MATRIX]  = wrap || ref_ok;
  assign set_v[FLG_COMPARE] = match;
  assign clr_v[FLG_MATRIX]  = clr_matrix_irq;
  assign clr_v[FLG_COMPARE] = clr_compare_irq;

  // status flag and interrupt bit per event, kept as separate registers
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    tt_sticky_flag u_stat (
      .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(flag_q[g]));
    tt_sticky_flag u_irq (
      .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(irq_q[g]));
  end

  always_comb begin
    status_word              = '0;
    status_word[POS_MATRIX]  = flag_q[FLG_MATRIX];
    status_word[POS_COMPARE] = flag_q[FLG_COMPARE];
  end

  assign irq_matrix  = irq_q[FLG_MATRIX];
  assign irq_compare = irq_q[FLG_COMPARE];

  // R2: unused bits stay zero
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15:5] == '0) && (status_word[2:0] == '0));
  // R4: a wrap sets the matrix flag
  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !cycle_reload && cycle_count == cfg_cycle_max)
      |=> status_word[POS_MATRIX]);
  // R5: a gated reference completion sets the matrix flag
  p_ref_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && cycle_count == '0 && cfg_cycle_max != 3'b111)
      |=> status_word[POS_MATRIX]);
  // R7: an enabled match sets the compare flag
  p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_value == cycle_time) |=> (status_word[POS_COMPARE] && irq_compare));
  // R6: flag and interrupt bit move together
  p_irq_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_matrix == status_word[POS_MATRIX]) && (irq_compare == status_word[POS_COMPARE]));
endmodule

// File: tb/tt_cycle_status_test.sv
module tt_cycle_status_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_start = 0, cycle_reload = 0, ref_done = 0;
  logic [2:0]  cfg_cycle_max = 3'd3, cfg_cycle_init = 3'd0;
  logic        cmp_en = 1'b1;
  logic [15:0] cmp_value = 16'd100, cycle_time = 16'd0;
  logic        clr_matrix_irq = 0, clr_compare_irq = 0;
  logic [15:0] status_word;
  logic        irq_matrix, irq_compare;
  logic [2:0]  cycle_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_cycle_status uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cycle_reload(cycle_reload),
    .ref_done(ref_done), .cfg_cycle_max(cfg_cycle_max), .cfg_cycle_init(cfg_cycle_init),
    .cmp_en(cmp_en), .cmp_value(cmp_value), .cycle_time(cycle_time),
    .clr_matrix_irq(clr_matrix_irq), .clr_compare_irq(clr_compare_irq),
    .status_word(status_word), .irq_matrix(irq_matrix), .irq_compare(irq_compare),
    .cycle_count(cycle_count));

  // row: start, ref, time_is_match, clr_matrix, clr_compare, exp_count[2:0], exp_b4, exp_b3
  localparam int NV = 16;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_1_0_0_0_000_1_0, // R5 ref at count 0
    10'b0_0_0_1_0_000_0_0, // R6 clear
    10'b1_0_0_0_0_001_0_0, // R3 step
    10'b0_1_0_0_0_001_0_0, // R5 ref at count 1 ignored
    10'b1_0_0_0_0_010_0_0,
    10'b1_0_0_0_0_011_0_0,
    10'b1_0_0_0_0_000_1_0, // R4 wrap
    10'b1_0_0_1_0_001_0_0, // R6 clear, no wrap
    10'b0_0_1_0_0_001_0_1, // R7 match
    10'b0_0_0_0_0_001_0_1, // R8 sticky
    10'b0_0_1_0_1_001_0_1, // R8 set wins
    10'b0_0_0_0_1_001_0_0, // R8 clear
    10'b1_0_0_0_0_010_0_0,
    10'b1_0_0_0_0_011_0_0,
    10'b1_0_0_1_0_000_1_0, // R6 wrap wins over clear
    10'b0_0_0_1_0_000_0_0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cycle_start = 0; cycle_reload = 0; ref_done = 0;
    clr_matrix_irq = 0; clr_compare_irq = 0;
  endtask

  task automatic check_state(input string req, input logic [2:0] cnt,
                             input logic b4, input logic b3);
    logic [15:0] exp_word;
    exp_word = 16'h0000;
    exp_word[4] = b4;
    exp_word[3] = b3;
    check(req, status_word, exp_word);
    check(req, {14'd0, irq_matrix, irq_compare}, {14'd0, b4, b3});
    check(req, {13'd0, cycle_count}, {13'd0, cnt});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_state("R1 reset", 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cycle_start     = VEC[i][9];
      ref_done        = VEC[i][8];
      cycle_time      = VEC[i][7] ? cmp_value : 16'd5;
      clr_matrix_irq  = VEC[i][6];
      clr_compare_irq = VEC[i][5];
      @(negedge clk);
      check_state($sformatf("R2 R3 table row %0d", i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end
    idle_inputs();
    cycle_time = 16'd5;

    // R7: equality ignored while disabled
    cmp_en = 1'b0; cycle_time = cmp_value;
    @(negedge clk);
    check_state("R7 disabled compare", 3'd0, 1'b0, 1'b0);
    cycle_time = 16'd5; cmp_en = 1'b1;

    // R5: maximum of 7 blocks the reference path
    cfg_cycle_max = 3'd7; ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    check_state("R5 max 7 ref ignored", 3'd0, 1'b0, 1'b0);

    // R4: full run to 7 then wrap
    cycle_start = 1'b1;
    for (int k = 1; k <= 7; k++) @(negedge clk);
    check_state("R3 count reaches 7", 3'd7, 1'b0, 1'b0);
    @(negedge clk);
    cycle_start = 1'b0;
    check_state("R4 wrap at max 7", 3'd0, 1'b1, 1'b0);
    clr_matrix_irq = 1'b1;
    @(negedge clk);
    clr_matrix_irq = 1'b0;
    check_state("R6 clear after wrap", 3'd0, 1'b0, 1'b0);

    // R3: reload beats start
    cfg_cycle_init = 3'd5; cycle_reload = 1'b1; cycle_start = 1'b1;
    @(negedge clk);
    idle_inputs();
    check_state("R3 reload priority", 3'd5, 1'b0, 1'b0);

    // R1: reset mid-run
    cycle_time = cmp_value;
    @(negedge clk);
    check_state("R7 set before reset", 3'd5, 1'b0, 1'b1);
    cycle_time = 16'd5;
    rst_n = 1'b0;
    @(negedge clk);
    check_state("R1 reset mid-run", 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule